// File: doc/BRIEF.md
# Page write buffer and commit sequencer

This block sits behind a two-wire serial slave engine in a small serial EEPROM. While a write transaction is open it takes a starting word address and then a stream of data bytes. It collects them in a one-page buffer. Only the low page-offset bits of the address advance, so a long burst wraps inside the page and replaces bytes it has already stored.

When the engine reports the stop condition, the block writes the buffered bytes to an external synchronous memory array, one per clock. It then holds a busy flag through a fixed write interval. A write-protect input cancels the commit entirely. Array size, page size and the length of the write interval are parameters. The interval is counted in system clocks.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low.
- R2: `txn_start_i` loads the pointer from `start_addr_i` and clears every stored byte mark. Bytes held from an earlier, uncommitted transaction are never written by a later commit.
- R3: Each accepted byte is stored at the current page offset. The offset (the low `PAGE_W` bits) then increments modulo the page size. The upper address bits never change within a transaction, so all writes of one commit share the page of `start_addr_i`.
- R4: When more bytes than the page holds are received, the later byte at a wrapped offset replaces the earlier one, and each offset is written at most once.
- R5: On commit, only offsets that received a byte are written. They are written in ascending offset order, with `mem_addr_o` = {page, offset} and `mem_wdata_o` = the last byte stored there.
- R6: A stop while `wp_i` is high writes nothing, and `busy_o` stays low.
- R7: After an accepted stop with at least one stored byte, `busy_o` rises in the next cycle and stays high for exactly 2^`PAGE_W` + `WR_CYCLES` cycles. All array writes fall inside that window.
- R8: While `busy_o` is high, `txn_start_i`, `byte_vld_i` and `stop_i` are ignored: they cause no write, they do not change the busy length, and they leave the block idle afterwards.
- R9: A stop with no stored byte, or a stop or byte outside an open transaction, writes nothing and does not raise `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_start_i | input | 1 | Opens a write transaction, one-cycle strobe |
| start_addr_i | input | ADDR_W | Word address taken with `txn_start_i` |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop condition strobe |
| wp_i | input | 1 | Write protect, high blocks the commit |
| busy_o | output | 1 | Commit and write interval in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The hardest case to reach is a commit that must leave out stale bytes. That means a buffer still holding marks from a transaction that was never committed. The bench builds it with a full burst closed under write protect, then opens a short transaction in a different page and checks that only the short one's offsets reach the array. A second difficult case is stimulus during the busy window. The bench drives starts, bytes and stops while it counts busy cycles, and then sends a lone stop to show that nothing was reopened.

// File: rtl/epc_pkg.sv
package epc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_COMMIT  = 2'd2,
    ST_WAIT    = 2'd3
  } epc_state_e;
endpackage

// File: rtl/epc_page_buf.sv
module epc_page_buf #(
  parameter int PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_off_i,
  input  logic [7:0]        wr_data_i,
  input  logic [PAGE_W-1:0] rd_off_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  localparam int PAGE_N = 1 << PAGE_W;

  logic [7:0]        data_q [PAGE_N];
  logic [PAGE_N-1:0] vld_q;

  for (genvar g = 0; g < PAGE_N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g]  <= 1'b0;
      end else if (wr_i && (wr_off_i == PAGE_W'(g))) begin
        data_q[g] <= wr_data_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = data_q[rd_off_i];
  assign rd_vld_o  = vld_q[rd_off_i];
  assign any_vld_o = |vld_q;
endmodule

// File: rtl/epc_cycle_timer.sv
module epc_cycle_timer #(
  parameter int WR_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(WR_CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/epc_sequencer.sv
module epc_sequencer
  import epc_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic              byte_vld_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              any_vld_i,
  input  logic              tmr_done_i,
  output logic              load_o,
  output logic              accept_o,
  output logic              scan_o,
  output logic [PAGE_W-1:0] scan_idx_o,
  output logic              tmr_start_o,
  output logic              busy_o
);
  localparam logic [PAGE_W-1:0] LAST_OFF = '1;

  epc_state_e        state_q, state_d;
  logic [PAGE_W-1:0] idx_q;

  always_comb begin
    state_d     = state_q;
    load_o      = 1'b0;
    accept_o    = 1'b0;
    tmr_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (txn_start_i) begin
          load_o  = 1'b1;
          state_d = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (txn_start_i) begin
          load_o = 1'b1;  // repeated start reopens
        end else if (stop_i) begin
          state_d = (!wp_i && any_vld_i) ? ST_COMMIT : ST_IDLE;
        end else if (byte_vld_i) begin
          accept_o = 1'b1;
        end
      end
      ST_COMMIT: begin
        if (idx_q == LAST_OFF) begin
          state_d     = ST_WAIT;
          tmr_start_o = 1'b1;
        end
      end
      ST_WAIT: begin
        if (tmr_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_COMMIT) idx_q <= idx_q + 1'b1;
      else                      idx_q <= '0;
    end
  end

  assign scan_o     = (state_q == ST_COMMIT);
  assign scan_idx_o = idx_q;
  assign busy_o     = (state_q == ST_COMMIT) || (state_q == ST_WAIT);
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [ROW_W-1:0]  row_q;
  logic [PAGE_W-1:0] off_q;
  logic              load, accept, scan, tmr_start, tmr_done, any_vld, rd_vld;
  logic [PAGE_W-1:0] scan_idx;
  logic [7:0]        rd_data;

  epc_sequencer #(.PAGE_W(PAGE_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .txn_start_i (txn_start_i),
    .byte_vld_i  (byte_vld_i),
    .stop_i      (stop_i),
    .wp_i        (wp_i),
    .any_vld_i   (any_vld),
    .tmr_done_i  (tmr_done),
    .load_o      (load),
    .accept_o    (accept),
    .scan_o      (scan),
    .scan_idx_o  (scan_idx),
    .tmr_start_o (tmr_start),
    .busy_o      (busy_o)
  );

  epc_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load),
    .wr_i      (accept),
    .wr_off_i  (off_q),
    .wr_data_i (byte_i),
    .rd_off_i  (scan_idx),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .any_vld_o (any_vld)
  );

  epc_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .done_o  (tmr_done)
  );

  // pointer: row fixed per transaction, offset wraps within the page
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      off_q <= '0;
    end else if (load) begin
      row_q <= start_addr_i[ADDR_W-1:PAGE_W];
      off_q <= start_addr_i[PAGE_W-1:0];
    end else if (accept) begin
      off_q <= off_q + 1'b1;
    end
  end

  assign mem_we_o    = scan && rd_vld;
  assign mem_addr_o  = {row_q, scan_idx};
  assign mem_wdata_o = rd_data;
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam int BUSY_LEN = (1 << PAGE_W) + WR_CYCLES;
  localparam int RUN_W    = $clog2(BUSY_LEN + 2);

  logic [RUN_W-1:0] run_q;
  logic [ADDR_W-1:0] last_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= '0;
      last_addr_q <= '0;
    end else begin
      run_q       <= busy_o ? run_q + 1'b1 : '0;
      last_addr_q <= mem_addr_o;
    end
  end

  a_r7_we_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  a_r7_busy_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i) && !$past(wp_i));

  a_r7_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == RUN_W'(BUSY_LEN)));

  a_r6_wp_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wp_i && !busy_o) |=> !busy_o);

  a_r3_row_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && mem_we_o) |->
      (mem_addr_o[ADDR_W-1:PAGE_W] == last_addr_q[ADDR_W-1:PAGE_W]));
endmodule

bind eeprom_page_commit epc_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .wp_i       (wp_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/sim_eeprom_page_commit.sv
module sim_eeprom_page_commit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int PAGE_W     = 3;
  localparam int WR_CYCLES  = 20;
  localparam int PAGE_N     = 1 << PAGE_W;
  localparam int BUSY_LEN   = PAGE_N + WR_CYCLES;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              txn_start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic              byte_vld_i = 1'b0;
  logic [7:0]        byte_i = '0;
  logic              stop_i = 1'b0;
  logic              wp_i = 1'b0;
  logic              busy_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [7:0]        mem_wdata_o;

  eeprom_page_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    n_run = 0, n_fail = 0;
  string cur_tag = "R5";
  logic [ADDR_W+7:0] exp_q[$];

  // bench model of the page being collected
  logic [7:0]        m_data [PAGE_N];
  logic [PAGE_N-1:0] m_vld;
  logic [ADDR_W-1:0] m_row_base;
  int                m_off;

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && mem_we_o) begin
      if (exp_q.size() == 0) begin
        check(cur_tag, 1'b0, {mem_addr_o, mem_wdata_o}, 0);
      end else begin
        logic [ADDR_W+7:0] e;
        e = exp_q.pop_front();
        check(cur_tag, {mem_addr_o, mem_wdata_o} == e, {mem_addr_o, mem_wdata_o}, e);
      end
    end
  end

  task automatic do_start(input logic [ADDR_W-1:0] a);
    @(negedge clk_i);
    txn_start_i = 1'b1; start_addr_i = a;
    @(negedge clk_i);
    txn_start_i = 1'b0;
    m_vld = '0;
    m_row_base = a & ~ADDR_W'(PAGE_N - 1);
    m_off = int'(a) % PAGE_N;
  endtask

  task automatic do_byte(input logic [7:0] d);
    byte_vld_i = 1'b1; byte_i = d;
    @(negedge clk_i);
    byte_vld_i = 1'b0;
    m_data[m_off] = d; m_vld[m_off] = 1'b1;
    m_off = (m_off + 1) % PAGE_N;
  endtask

  // stop, optionally poke inputs while busy; counts busy cycles
  task automatic do_stop(input logic wp, input logic poke, input string tag);
    int cnt;
    logic commit;
    commit = !wp && (m_vld != '0);
    if (commit)
      for (int i = 0; i < PAGE_N; i++)
        if (m_vld[i]) exp_q.push_back({m_row_base | ADDR_W'(i), m_data[i]});
    wp_i = wp; stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0; wp_i = 1'b0;
    cnt = 0;
    for (int k = 0; k < BUSY_LEN + 10; k++) begin
      if (!busy_o) break;
      cnt++;
      if (poke) begin
        txn_start_i = (k % 3 == 0); start_addr_i = 8'h70;
        byte_vld_i  = (k % 3 == 1); byte_i = 8'hEE;
        stop_i      = (k % 3 == 2);
      end
      @(negedge clk_i);
      txn_start_i = 1'b0; byte_vld_i = 1'b0; stop_i = 1'b0;
    end
    check(tag, cnt == (commit ? BUSY_LEN : 0), cnt, commit ? BUSY_LEN : 0);
    check(tag, exp_q.size() == 0, exp_q.size(), 0);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk_i);
    check("watchdog", 1'b0, 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_vld = '0; m_off = 0; m_row_base = '0;
    for (int i = 0; i < PAGE_N; i++) m_data[i] = '0;
    #(CLK_PERIOD*2 + 2);
    check("R1", busy_o == 1'b0, busy_o, 0);
    check("R1", mem_we_o == 1'b0, mem_we_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", busy_o == 1'b0, busy_o, 0);

    // R5 partial page, mid-page start
    cur_tag = "R5";
    do_start(8'h13);
    do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
    do_stop(1'b0, 1'b0, "R5");

    // R3 offset wraps, row fixed
    cur_tag = "R3";
    do_start(8'h46);
    do_byte(8'hB0); do_byte(8'hB1); do_byte(8'hB2);
    do_stop(1'b0, 1'b0, "R3");

    // R4 overflow beyond page overwrites
    cur_tag = "R4";
    do_start(8'h2D);
    for (int i = 0; i < PAGE_N + 2; i++) do_byte(8'hC0 + 8'(i));
    do_stop(1'b0, 1'b0, "R4");

    // R6 write protect: full page, no commit
    cur_tag = "R6";
    do_start(8'h58);
    for (int i = 0; i < PAGE_N; i++) do_byte(8'hD0 + 8'(i));
    do_stop(1'b1, 1'b0, "R6");

    // R2 stale marks cleared by the next start
    cur_tag = "R2";
    do_start(8'h91);
    do_byte(8'h5A);
    do_stop(1'b0, 1'b0, "R2");

    // R9 empty transaction and stray inputs while idle
    cur_tag = "R9";
    do_start(8'h30);
    do_stop(1'b0, 1'b0, "R9");
    byte_vld_i = 1'b1; byte_i = 8'h11;
    @(negedge clk_i);
    byte_vld_i = 1'b0;
    m_vld = '0;
    do_stop(1'b0, 1'b0, "R9");

    // R7 R8 busy length with inputs poked during busy
    cur_tag = "R8";
    do_start(8'hF7);
    do_byte(8'h77); do_byte(8'h78);
    do_stop(1'b0, 1'b1, "R7");
    m_vld = '0;
    do_stop(1'b0, 1'b0, "R8");
    check("R8", busy_o == 1'b0, busy_o, 0);

    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule